// File: doc/BRIEF.md
# Phase-Accumulator Timed Buffered Serial Transmitter

This block sends bytes as asynchronous serial characters: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Bytes arrive on a write strobe. A byte is taken on every clock where the strobe is high, so a burst of back-to-back strobes loads a run of bytes. The bytes wait in a 16-entry FIFO until a whole frame of `FRAME_LEN` bytes (5 by default) is present. The frame is then sent with no idle time between characters.

Bit timing comes from a 32-bit phase accumulator. The `phase_inc` input is added to it on every active clock, and each carry out is one tick. Setting `phase_inc = 4 * baud * 2^32 / f_clk` gives ticks at four times the bit rate. Each bit lasts four ticks, so the baud rate can be changed at run time without a divider. A driver-enable output brackets every frame, so a half-duplex RS485 transceiver can drive the line only while the block is sending.

The controller has five states:
- IDLE: line high, driver off.
- LEAD: driver on, waiting one tick before the first start bit.
- START: start bit.
- DATA: data bits.
- STOP: stop bit.

The transitions are:
- IDLE→LEAD when the FIFO level reaches the frame length.
- LEAD→START on a tick, which pops the first byte.
- START→DATA after four ticks.
- DATA→DATA after each bit.
- DATA→STOP after the eighth bit.
- STOP→START after four ticks, popping the next byte, while characters remain in the frame.
- STOP→IDLE when the last character is done.

Top module: `nco_uart_tx`

## Requirements
- R1: While reset is high and afterwards whenever no frame is in progress, `tx_line` is 1 and `drv_en` is 0. `ovf_flag` is 0 after reset.
- R2: Each character is a start bit of 0, then the 8 data bits with bit 0 first, then a stop bit of 1. Each bit lasts exactly 4 ticks. With `phase_inc = 32'h4000_0000` a tick comes every 4 clocks, so each bit lasts 16 clocks.
- R3: A tick is the carry out of the 32-bit accumulator plus the latched increment. The accumulator is cleared while idle. With an increment of 0 no tick occurs and the line does not move.
- R4: A byte is stored on every clock where `wr_stb` is 1 and the FIFO is not full, including on consecutive clocks.
- R5: A frame begins only when the FIFO holds at least `FRAME_LEN` bytes. With fewer bytes stored, `drv_en` stays 0 and `tx_line` stays 1.
- R6: The characters of a frame follow one another with no gap. The next start bit begins at the clock the previous stop bit ends, so start edges are 160 clocks apart at the R2 rate.
- R7: `drv_en` rises exactly one tick (4 clocks at the R2 rate) before the first start bit. It falls at the clock where the last stop bit ends, 160 clocks after that character's start edge.
- R8: The FIFO holds 16 bytes. A write while it is full is dropped and sets `ovf_flag`, which then stays 1 until reset.
- R9: The increment is latched only while idle, while waiting in LEAD, and at each character boundary. A change in the middle of a character does not alter that character's timing.
- R10: Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| phase_inc | input | 32 | Accumulator increment per clock (4 × baud × 2^32 / f_clk) |
| wr_data | input | 8 | Byte to enqueue |
| wr_stb | input | 1 | Write strobe; one byte per high clock |
| tx_line | output | 1 | Serial output, idles high |
| drv_en | output | 1 | Line-driver enable, high only during a frame |
| ovf_flag | output | 1 | Sticky flag: a write was dropped on a full FIFO |

## Verification
The bench builds the block with its default parameters:
- `FRAME_LEN` = 5
- FIFO depth = 16
- 4 ticks per bit
- 32-bit accumulator

With these values, a burst of 17 strobes reaches the full-FIFO drop. It also leaves one byte behind after three frames, which exercises the below-frame wait.

Most of the run uses an increment of one quarter of the accumulator range, so every bit edge falls on an exact clock. This allows the lead time, character spacing and driver-release timing to be checked to the cycle. An increment of zero parks the controller in LEAD while the FIFO fills. A short excursion of the increment in the middle of a character shows that the latched value governs timing.

// File: rtl/nco_uart_pkg.sv
package nco_uart_pkg;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_LEAD  = 3'd1,
        TX_START = 3'd2,
        TX_DATA  = 3'd3,
        TX_STOP  = 3'd4
    } tx_state_t;

endpackage

// File: rtl/nco_tick_gen.sv
module nco_tick_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc} + {1'b0, inc};
    assign tick = run & sum[ACC_W];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            acc <= '0;
        end else if (!run) begin
            acc <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end

    // R3: below half range, a tick can never follow a tick directly
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(tick) && inc == $past(inc) && !inc[ACC_W-1]) |-> !tick);

    // R3: zero increment never produces a tick
    p_zero_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && inc == '0 && $past(inc) == '0 && !$past(tick)) |-> !tick);

endmodule

// File: rtl/nco_byte_fifo.sv
module nco_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              ovf
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              push;

    assign full    = (level == LVL_W'(DEPTH));
    assign push    = wr_en && !full;
    assign rd_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, rd_en})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
            if (wr_en && full) begin
                ovf <= 1'b1;
            end
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) |-> ovf);

    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (level == LVL_W'(DEPTH)) && ovf);

endmodule

// File: rtl/nco_tx_serializer.sv
module nco_tx_serializer
    import nco_uart_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ACC_W         = 32,
    parameter int FRAME_LEN     = 5,
    parameter int TICKS_PER_BIT = 4,
    parameter int LVL_W         = 5,
    localparam int TC_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int BIT_W = $clog2(DATA_W),
    localparam int CL_W  = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  inc_in,
    input  logic              tick,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [DATA_W-1:0] fifo_head,
    output logic [ACC_W-1:0]  inc_lat,
    output logic              pop,
    output logic              run,
    output logic              tx,
    output logic              de
);

    tx_state_t         state, nxt;
    logic [TC_W-1:0]   tick_cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [CL_W-1:0]   chars_left;
    logic              bit_done;
    logic              frame_ready;

    assign bit_done    = tick && (tick_cnt == TC_W'(TICKS_PER_BIT - 1));
    assign frame_ready = (fifo_level >= LVL_W'(FRAME_LEN));

    // next state and pop request
    always_comb begin
        nxt = state;
        pop = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (frame_ready) nxt = TX_LEAD;
            end
            TX_LEAD: begin
                if (tick) begin
                    nxt = TX_START;
                    pop = 1'b1;
                end
            end
            TX_START: begin
                if (bit_done) nxt = TX_DATA;
            end
            TX_DATA: begin
                if (bit_done && bit_idx == BIT_W'(DATA_W - 1)) nxt = TX_STOP;
            end
            TX_STOP: begin
                if (bit_done) begin
                    if (chars_left != '0) begin
                        nxt = TX_START;
                        pop = 1'b1;
                    end else begin
                        nxt = TX_IDLE;
                    end
                end
            end
            default: nxt = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= TX_IDLE;
        else     state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            tick_cnt   <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            chars_left <= '0;
            inc_lat    <= '0;
        end else begin
            if (state == TX_IDLE || state == TX_LEAD || (state == TX_STOP && bit_done)) begin
                inc_lat <= inc_in;
            end
            if (state == TX_IDLE || state == TX_LEAD) begin
                tick_cnt <= '0;
            end else if (tick) begin
                tick_cnt <= bit_done ? '0 : tick_cnt + TC_W'(1);
            end
            if (state == TX_IDLE && frame_ready) begin
                chars_left <= CL_W'(FRAME_LEN - 1);
            end else if (state == TX_STOP && bit_done && chars_left != '0) begin
                chars_left <= chars_left - CL_W'(1);
            end
            if (pop) begin
                shreg   <= fifo_head;
                bit_idx <= '0;
            end else if (state == TX_DATA && bit_done) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        run = 1'b1;
        tx  = 1'b1;
        de  = 1'b1;
        unique case (state)
            TX_IDLE:  begin run = 1'b0; de = 1'b0; end
            TX_LEAD:  tx = 1'b1;
            TX_START: tx = 1'b0;
            TX_DATA:  tx = shreg[0];
            TX_STOP:  tx = 1'b1;
            default:  begin run = 1'b0; de = 1'b0; end
        endcase
    end

    // R10: never pop an empty FIFO
    p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fifo_level != '0));

    // R9: latched increment frozen inside start and data bits
    p_inc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state == TX_DATA || state == TX_START) |=> $stable(inc_lat));

    // R7: leaving LEAD puts a start bit on the line with the driver on
    p_lead_to_start_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == TX_LEAD && state == TX_START) |-> (!tx && de));

    // R1: line is high whenever the driver is off
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !de |-> tx);

    // R5: a frame only starts with a full frame buffered
    p_frame_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && fifo_level < LVL_W'(FRAME_LEN)) |=> !de);

endmodule

// File: rtl/nco_uart_tx.sv
module nco_uart_tx #(
    parameter int DATA_W        = 8,
    parameter int ACC_W         = 32,
    parameter int FIFO_DEPTH    = 16,
    parameter int FRAME_LEN     = 5,
    parameter int TICKS_PER_BIT = 4,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  phase_inc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stb,
    output logic              tx_line,
    output logic              drv_en,
    output logic              ovf_flag
);

    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] head;
    logic              pop;
    logic              run;
    logic              tick;
    logic [ACC_W-1:0]  inc_lat;

    nco_byte_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_stb),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .level   (level),
        .ovf     (ovf_flag)
    );

    nco_tick_gen #(
        .ACC_W (ACC_W)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .inc  (inc_lat),
        .tick (tick)
    );

    nco_tx_serializer #(
        .DATA_W        (DATA_W),
        .ACC_W         (ACC_W),
        .FRAME_LEN     (FRAME_LEN),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .LVL_W         (LVL_W)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .inc_in     (phase_inc),
        .tick       (tick),
        .fifo_level (level),
        .fifo_head  (head),
        .inc_lat    (inc_lat),
        .pop        (pop),
        .run        (run),
        .tx         (tx_line),
        .de         (drv_en)
    );

    // R4: a strobe on a non-full FIFO does not set overflow
    p_accept_no_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && level < LVL_W'(FIFO_DEPTH) && !ovf_flag) |=> !ovf_flag);

endmodule

// File: tb/nco_uart_tx_bench.sv
module nco_uart_tx_bench;

    localparam logic [31:0] INC_Q = 32'h4000_0000;
    localparam int BITC = 16;
    localparam int CHARC = 10 * BITC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] phase_inc = INC_Q;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_stb = 1'b0;
    logic        tx_line;
    logic        drv_en;
    logic        ovf_flag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rx_count = 0;
    bit lead_chk = 1'b1;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nco_uart_tx u_nco_uart_tx (
        .clk       (clk),
        .rst       (rst),
        .phase_inc (phase_inc),
        .wr_data   (wr_data),
        .wr_stb    (wr_stb),
        .tx_line   (tx_line),
        .drv_en    (drv_en),
        .ovf_flag  (ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [7:0] rev_bits(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev_bits[i] = b[7 - i];
    endfunction

    // writes one byte on the strobe; call at a negedge
    task automatic wr1(input logic [7:0] b, input bit expect_keep);
        wr_data = b;
        wr_stb  = 1'b1;
        if (expect_keep) exp_q.push_back(b);
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        while (rx_count < n) @(negedge clk);
    endtask

    // line monitor: decodes characters and checks frame timing
    initial begin : monitor
        bit in_frame;
        bit first_char;
        int de_rise;
        int prev_start;
        int t0;
        logic [7:0] got;
        logic [7:0] expb;
        in_frame = 1'b0;
        first_char = 1'b0;
        de_rise = 0;
        prev_start = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (drv_en && !in_frame) begin
                    in_frame = 1'b1;
                    first_char = 1'b1;
                    de_rise = cyc;
                end
                if (!drv_en && in_frame) begin
                    in_frame = 1'b0;
                    chk("R7 driver release", cyc - prev_start, CHARC);
                end
                if (tx_line === 1'b0) begin
                    t0 = cyc;
                    chk("R1 driver on during character", {31'd0, drv_en}, 32'd1);
                    if (first_char) begin
                        if (lead_chk) chk("R7 lead time", t0 - de_rise, 4);
                        first_char = 1'b0;
                    end else begin
                        chk("R6 back-to-back spacing", t0 - prev_start, CHARC);
                    end
                    repeat (BITC / 2) @(negedge clk);
                    chk("R2 start bit", {31'd0, tx_line}, 32'd0);
                    for (int i = 0; i < 8; i++) begin
                        repeat (BITC) @(negedge clk);
                        got[i] = tx_line;
                    end
                    repeat (BITC) @(negedge clk);
                    chk("R2 stop bit", {31'd0, tx_line}, 32'd1);
                    if (exp_q.size() == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL R10 unexpected byte actual=%0h expected=none", got);
                    end else begin
                        expb = exp_q.pop_front();
                        chk("R2/R10 data LSB first in order", {24'd0, got}, {24'd0, expb});
                        if (got !== expb && got === rev_bits(expb))
                            $display("note: byte arrived bit-reversed");
                    end
                    prev_start = t0;
                    rx_count++;
                    repeat (BITC / 2 - 1) @(negedge clk);
                end
            end
        end
    end

    initial begin : watchdog
        wait (cyc > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int seed;
        int base;
        seed = $urandom(32'd20240601);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx high in reset", {31'd0, tx_line}, 32'd1);
        chk("R1 driver off in reset", {31'd0, drv_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx idle high", {31'd0, tx_line}, 32'd1);
        chk("R1 driver idle off", {31'd0, drv_en}, 32'd0);
        chk("R1 overflow clear", {31'd0, ovf_flag}, 32'd0);

        // R4/R2: one frame written on consecutive strobes
        wr1(8'h3C, 1); wr1(8'hA5, 1); wr1(8'h81, 1); wr1(8'h00, 1); wr1(8'hFF, 1);
        wait_rx(5);

        // R5: four bytes are not a frame
        wr1(8'h12, 1); wr1(8'h34, 1); wr1(8'h56, 1); wr1(8'h78, 1);
        repeat (400) @(negedge clk);
        chk("R5 no start below frame", {31'd0, drv_en}, 32'd0);
        chk("R5 line idle below frame", {31'd0, tx_line}, 32'd1);
        wr1(8'h9A, 1);
        wait_rx(10);

        // R9: increment excursion in the middle of the last character
        wr1(8'h5A, 1); wr1(8'hC3, 1); wr1(8'h01, 1); wr1(8'h80, 1); wr1(8'h6E, 1);
        wait_rx(14);
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        phase_inc = 32'h0000_0100;
        repeat (30) @(negedge clk);
        phase_inc = INC_Q;
        wait_rx(15);
        repeat (20) @(negedge clk);
        chk("R9 frame ended on time", {31'd0, drv_en}, 32'd0);

        // R3/R8: zero increment parks the sender while the FIFO overfills
        phase_inc = 32'd0;
        lead_chk = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 17; i++) wr1(8'(8'h20 + i), i < 16);
        chk("R8 overflow set", {31'd0, ovf_flag}, 32'd1);
        repeat (100) @(negedge clk);
        chk("R3 no ticks at zero increment", {31'd0, tx_line}, 32'd1);
        chk("R3 driver held during stall", {31'd0, drv_en}, 32'd1);
        base = rx_count;
        phase_inc = INC_Q;
        wait_rx(base + 1);
        lead_chk = 1'b1;
        wait_rx(base + 15);
        repeat (300) @(negedge clk);
        chk("R5 leftover byte waits", {31'd0, drv_en}, 32'd0);
        wr1(8'hE1, 1); wr1(8'hE2, 1); wr1(8'hE3, 1); wr1(8'hE4, 1);
        wait_rx(base + 20);
        chk("R8 overflow sticky", {31'd0, ovf_flag}, 32'd1);

        // R4/R10: random bytes with random strobe gaps
        for (int f = 0; f < 6; f++) begin
            base = rx_count;
            for (int k = 0; k < 5; k++) begin
                wr1(8'($urandom), 1);
                repeat ($urandom % 4) @(negedge clk);
            end
            wait_rx(base + 5);
        end
        repeat (200) @(negedge clk);
        chk("R10 all bytes delivered", exp_q.size(), 0);
        chk("R1 idle after traffic", {31'd0, tx_line}, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule